// File: doc/BRIEF.md
# Load-Use Interlock and Forwarding Controller

This block tracks instruction metadata through an eight-stage in-order integer pipeline. The stages, in order, are fetch, issue, register read, execute, data-first, data-second, tag-check and writeback. Each cycle the fetch side presents one instruction: a valid bit, a load flag, a destination register and two source registers. The block moves that metadata down its own stage registers. It raises hold enables for the front of the pipe, injects bubbles and drives one forward select per source operand for the instruction in execute.

A load's data is usable only at the end of data-second. The architecture has no software load delay slot, so a consumer that sits right behind a load must still see the loaded value. It must never see the old register contents. When the consumer in execute needs a load that is still in data-first, the block freezes fetch, issue, register read and execute for one cycle. Data-first receives a bubble, and the back stages keep draining. On the next cycle the load sits in data-second. Its data is then routed late into the consumer's result path through the forward select, and the freeze is lifted in that same cycle. Results of non-load instructions are forwarded with no freeze. A flush empties every tracked stage.

Top module: `load_use_interlock`

## Requirements
- R1: While reset is applied and on the first cycle after it, every `stageValid` bit, `stageHold`, `bubbleInsert`, `fwdSelA` and `fwdSelB` are zero.
- R2: `bubbleInsert` is 1 exactly when all of these hold and `flush` is low: the execute instruction is valid, the data-first instruction is a valid load with a nonzero destination, and either execute source equals that destination. In that cycle `stageHold` bits 0 to 3 (fetch, issue, register read, execute) are 1, and bits 4 to 7 (data-first to writeback) are 0 in every cycle.
- R3: In a freeze cycle the issue, register-read and execute stages keep their contents. On the next cycle data-first holds an invalid bubble, and data-second holds what data-first held.
- R4: A source register number of 0 never causes a freeze and always yields forward select 0.
- R5: A load directly followed by its consumer costs exactly one freeze cycle. When the load is in data-second and the consumer is in execute, no freeze occurs and the select is 2 (late forward of load data).
- R6: A non-load result in data-first that matches an execute source is forwarded with select 1 and no freeze.
- R7: Each forward select picks the youngest valid writer of its source among the later stages. The encoding is 0 = register file, 1 = data-first, 2 = data-second, 3 = tag-check, 4 = writeback. The two sources are resolved independently.
- R8: When `flush` is high, the next cycle shows every `stageValid` bit at 0. The fetch input offered in the flush cycle is discarded, and no hold or bubble is raised in the flush cycle.
- R9: Outside freeze and flush, all tracked stages advance by one each cycle. The fetch input enters issue, so `stageValid` bit 0 (issue) up to bit 6 (writeback) shifts up by one.
- R10: The fetch input offered during a freeze cycle is not taken into the pipe and has no effect on later valid bits, holds or selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Discard every instruction in flight |
| ifValid | input | 1 | Fetch instruction is valid |
| ifIsLoad | input | 1 | Fetch instruction is a load |
| ifDest | input | REG_ADDR_W | Destination register of fetch instruction (0 = none) |
| ifSrcA | input | REG_ADDR_W | First source register (0 = unused) |
| ifSrcB | input | REG_ADDR_W | Second source register (0 = unused) |
| stageHold | output | 8 | Hold enable per stage, bit 0 fetch to bit 7 writeback |
| bubbleInsert | output | 1 | Invalid slot injected into data-first this cycle |
| stageValid | output | 7 | Valid bits, bit 0 issue to bit 6 writeback |
| fwdSelA | output | 3 | Operand source for execute's first source |
| fwdSelB | output | 3 | Operand source for execute's second source |

## Verification
Several kinds of stream are driven:
- An independent stream, with no register overlap, shows pure advancement with no spurious freeze.
- A load with its consumer adjacent is compared with a load whose consumer sits one slot later. This separates the single freeze from the freeze-free late forward out of data-second.
- An arithmetic producer with an adjacent consumer checks forwarding with no freeze.
- A register-0 load checks that register 0 never freezes or forwards.
- Repeated writers of one register check youngest-first priority, and split writers check that the two operands are resolved separately.
- A flush in the middle of a freeze checks that flush wins.
- A long pseudo-random stream over four registers mixes all of these, including fetch inputs offered and dropped during freezes.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  localparam int NUM_STAGES = 8;
  localparam int ST_IS = 1;
  localparam int ST_RF = 2;
  localparam int ST_EX = 3;
  localparam int ST_DF = 4;
  localparam int ST_DS = 5;
  localparam int ST_TC = 6;
  localparam int ST_WB = 7;
  localparam int NUM_WRITERS = ST_WB - ST_DF + 1;
  localparam int FWD_W = 3;
  localparam int NUM_SRC = 2;

  typedef enum logic [FWD_W-1:0] {
    FWD_REGFILE = 3'd0,
    FWD_DF      = 3'd1,
    FWD_DS      = 3'd2,
    FWD_TC      = 3'd3,
    FWD_WB      = 3'd4
  } fwdSrcE;

  typedef struct packed {
    logic holdFront;
    logic insertBubble;
    logic flushAll;
  } ctrlStrobesT;
endpackage

// File: rtl/ilk_stage_track.sv
module ilk_stage_track
  import ilk_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobesT                   strobes,
  input  logic                          ifValid,
  input  logic                          ifIsLoad,
  input  logic [REG_W-1:0]              ifDest,
  input  logic [REG_W-1:0]              ifSrcA,
  input  logic [REG_W-1:0]              ifSrcB,
  output logic [NUM_STAGES-1:1]         stValid,
  output logic                          dfIsLoad,
  output logic [REG_W-1:0]              exSrcA,
  output logic [REG_W-1:0]              exSrcB,
  output logic [NUM_WRITERS-1:0][REG_W-1:0] wrDest
);
  logic [NUM_STAGES-1:1]             vld;
  logic [NUM_STAGES-1:1][REG_W-1:0]  dst;
  logic [ST_EX:1][REG_W-1:0]         srcA;
  logic [ST_EX:1][REG_W-1:0]         srcB;
  logic [ST_DF:1]                    ld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld  <= '0;
      dst  <= '0;
      srcA <= '0;
      srcB <= '0;
      ld   <= '0;
    end else if (strobes.flushAll) begin
      vld <= '0;
    end else begin
      if (!strobes.holdFront) begin
        vld[ST_EX:ST_IS]  <= {vld[ST_RF:ST_IS], ifValid};
        dst[ST_EX:ST_IS]  <= {dst[ST_RF:ST_IS], ifDest};
        srcA              <= {srcA[ST_RF:ST_IS], ifSrcA};
        srcB              <= {srcB[ST_RF:ST_IS], ifSrcB};
        ld[ST_EX:ST_IS]   <= {ld[ST_RF:ST_IS], ifIsLoad};
      end
      if (strobes.insertBubble) begin
        vld[ST_DF] <= 1'b0;
        dst[ST_DF] <= '0;
        ld[ST_DF]  <= 1'b0;
      end else begin
        vld[ST_DF] <= vld[ST_EX];
        dst[ST_DF] <= dst[ST_EX];
        ld[ST_DF]  <= ld[ST_EX];
      end
      vld[ST_WB:ST_DS] <= vld[ST_TC:ST_DF];
      dst[ST_WB:ST_DS] <= dst[ST_TC:ST_DF];
    end
  end

  assign stValid  = vld;
  assign dfIsLoad = ld[ST_DF];
  assign exSrcA   = srcA[ST_EX];
  assign exSrcB   = srcB[ST_EX];
  assign wrDest   = dst[ST_WB:ST_DF];

  // R8: a flush leaves every tracked stage empty
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flushAll |=> (vld == '0));

  // R3: the bubble lands in data-first while the frozen load moves on
  p_bubble_into_df_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.insertBubble && !strobes.flushAll) |=>
      (!vld[ST_DF] && vld[ST_DS] && $stable(vld[ST_EX:ST_IS])));

  // R9: free-running advance of every stage
  p_shift_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.holdFront && !strobes.insertBubble && !strobes.flushAll) |=>
      (vld[ST_WB:ST_RF] == $past(vld[ST_TC:ST_IS])));
endmodule

// File: rtl/ilk_hazard_ctrl.sv
module ilk_hazard_ctrl
  import ilk_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             exValid,
  input  logic             dfValid,
  input  logic             dfIsLoad,
  input  logic [REG_W-1:0] dfDest,
  input  logic [REG_W-1:0] exSrcA,
  input  logic [REG_W-1:0] exSrcB,
  output ctrlStrobesT      strobes
);
  logic loadPending;
  logic srcHit;
  logic stallNow;

  always_comb begin
    loadPending = dfValid && dfIsLoad && (dfDest != '0);
    srcHit      = (exSrcA == dfDest) || (exSrcB == dfDest);
    stallNow    = exValid && loadPending && srcHit && !flush;
    strobes.holdFront    = stallNow;
    strobes.insertBubble = stallNow;
    strobes.flushAll     = flush;
  end

  // R5: the load leaves data-first, so a freeze never lasts two cycles
  p_single_freeze_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.insertBubble |=> !strobes.insertBubble);
endmodule

// File: rtl/ilk_fwd_pick.sv
module ilk_fwd_pick
  import ilk_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [REG_W-1:0]                  srcNum,
  input  logic [NUM_WRITERS-1:0]            wrValid,
  input  logic [NUM_WRITERS-1:0][REG_W-1:0] wrDest,
  output fwdSrcE                            sel
);
  logic [FWD_W-1:0] code;

  // oldest first, so the youngest match overwrites
  always_comb begin
    code = '0;
    if (srcNum != '0) begin
      for (int k = NUM_WRITERS - 1; k >= 0; k--) begin
        if (wrValid[k] && (wrDest[k] == srcNum)) code = FWD_W'(k + 1);
      end
    end
    sel = fwdSrcE'(code);
  end

  // R4: register zero is never forwarded
  p_zero_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    (srcNum == '0) |-> (sel == FWD_REGFILE));
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import ilk_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  flush,
  input  logic                  ifValid,
  input  logic                  ifIsLoad,
  input  logic [REG_ADDR_W-1:0] ifDest,
  input  logic [REG_ADDR_W-1:0] ifSrcA,
  input  logic [REG_ADDR_W-1:0] ifSrcB,
  output logic [NUM_STAGES-1:0] stageHold,
  output logic                  bubbleInsert,
  output logic [NUM_STAGES-2:0] stageValid,
  output logic [FWD_W-1:0]      fwdSelA,
  output logic [FWD_W-1:0]      fwdSelB
);
  ctrlStrobesT                                strobes;
  logic [NUM_STAGES-1:1]                      stValid;
  logic                                       dfIsLoad;
  logic [REG_ADDR_W-1:0]                      exSrcA;
  logic [REG_ADDR_W-1:0]                      exSrcB;
  logic [NUM_WRITERS-1:0][REG_ADDR_W-1:0]     wrDest;
  logic [NUM_SRC-1:0][REG_ADDR_W-1:0]         srcNums;
  fwdSrcE                                     selArr [NUM_SRC];

  ilk_stage_track #(.REG_W(REG_ADDR_W)) uTrack (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .ifValid(ifValid), .ifIsLoad(ifIsLoad), .ifDest(ifDest),
    .ifSrcA(ifSrcA), .ifSrcB(ifSrcB),
    .stValid(stValid), .dfIsLoad(dfIsLoad),
    .exSrcA(exSrcA), .exSrcB(exSrcB), .wrDest(wrDest)
  );

  ilk_hazard_ctrl #(.REG_W(REG_ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .exValid(stValid[ST_EX]), .dfValid(stValid[ST_DF]),
    .dfIsLoad(dfIsLoad), .dfDest(wrDest[0]),
    .exSrcA(exSrcA), .exSrcB(exSrcB), .strobes(strobes)
  );

  assign srcNums = {exSrcB, exSrcA};

  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
    ilk_fwd_pick #(.REG_W(REG_ADDR_W)) uPick (
      .clk(clk), .rstN(rstN), .srcNum(srcNums[s]),
      .wrValid(stValid[ST_WB:ST_DF]), .wrDest(wrDest), .sel(selArr[s])
    );
  end

  assign stageHold    = {{(NUM_STAGES-ST_EX-1){1'b0}}, {(ST_EX+1){strobes.holdFront}}};
  assign bubbleInsert = strobes.insertBubble;
  assign stageValid   = stValid;
  assign fwdSelA      = selArr[0];
  assign fwdSelB      = selArr[1];

  // R2: a freeze is only ever raised against a valid load in data-first
  p_freeze_needs_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    bubbleInsert |-> (stValid[ST_DF] && stValid[ST_EX] && !flush));
endmodule

// File: tb/tb_load_use_interlock.sv
`timescale 1ns/1ps
module tb_load_use_interlock;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       flush = 1'b0;
  logic       ifValid = 1'b0;
  logic       ifIsLoad = 1'b0;
  logic [4:0] ifDest = '0;
  logic [4:0] ifSrcA = '0;
  logic [4:0] ifSrcB = '0;
  logic [7:0] stageHold;
  logic       bubbleInsert;
  logic [6:0] stageValid;
  logic [2:0] fwdSelA;
  logic [2:0] fwdSelB;

  always #2.5 clk = ~clk;

  load_use_interlock dut (
    .clk(clk), .rstN(rstN), .flush(flush), .ifValid(ifValid),
    .ifIsLoad(ifIsLoad), .ifDest(ifDest), .ifSrcA(ifSrcA), .ifSrcB(ifSrcB),
    .stageHold(stageHold), .bubbleInsert(bubbleInsert),
    .stageValid(stageValid), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB)
  );

  // reference model: index 1 = issue ... 7 = writeback
  int mv [8];
  int ml [8];
  int md [8];
  int ma [8];
  int mb [8];
  int checks = 0;
  int fails = 0;
  int bubbles = 0;
  int sawSel = 0;
  bit done = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pickSrc(int src);
    int r = 0;
    if (src == 0) return 0;
    for (int k = 7; k >= 4; k--) if (mv[k] != 0 && md[k] == src) r = k - 3;
    return r;
  endfunction

  task automatic step(int v, int l, int d, int a, int b, int fl, string tag);
    int stall;
    int expValid;
    ifValid = v[0]; ifIsLoad = l[0]; ifDest = d[4:0];
    ifSrcA = a[4:0]; ifSrcB = b[4:0]; flush = fl[0];
    #1;
    stall = (fl == 0 && mv[3] != 0 && mv[4] != 0 && ml[4] != 0 && md[4] != 0 &&
             (ma[3] == md[4] || mb[3] == md[4])) ? 1 : 0;
    expValid = 0;
    for (int k = 1; k <= 7; k++) if (mv[k] != 0) expValid |= (1 << (k - 1));
    check({"R2 bubble ", tag}, int'(bubbleInsert), stall);
    check({"R2 hold ", tag}, int'(stageHold), stall != 0 ? 8'h0F : 0);
    check({"R9 valid ", tag}, int'(stageValid), expValid);
    check({"R7 selA ", tag}, int'(fwdSelA), pickSrc(ma[3]));
    check({"R7 selB ", tag}, int'(fwdSelB), pickSrc(mb[3]));
    if (bubbleInsert) bubbles++;
    if (fwdSelA != 0) sawSel |= (1 << fwdSelA);
    if (fwdSelB != 0) sawSel |= (1 << fwdSelB);
    @(posedge clk);
    if (fl != 0) begin
      for (int k = 1; k <= 7; k++) mv[k] = 0;
    end else begin
      for (int k = 7; k >= 5; k--) begin
        mv[k] = mv[k-1]; ml[k] = ml[k-1]; md[k] = md[k-1];
      end
      if (stall != 0) begin
        mv[4] = 0; ml[4] = 0; md[4] = 0;
      end else begin
        for (int k = 4; k >= 2; k--) begin
          mv[k] = mv[k-1]; ml[k] = ml[k-1]; md[k] = md[k-1];
          ma[k] = ma[k-1]; mb[k] = mb[k-1];
        end
        mv[1] = v; ml[1] = l; md[1] = d; ma[1] = a; mb[1] = b;
      end
    end
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, "drain");
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      finishRun();
    end
  end

  initial begin
    logic [31:0] seed;
    for (int k = 0; k < 8; k++) begin mv[k]=0; ml[k]=0; md[k]=0; ma[k]=0; mb[k]=0; end
    ifValid = 1'b1; ifDest = 5'd3; ifSrcA = 5'd3;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(stageValid), 0);
    check("R1 reset bubble", int'(bubbleInsert) + int'(stageHold), 0);
    check("R1 reset sel", int'(fwdSelA) + int'(fwdSelB), 0);
    ifValid = 1'b0; ifDest = '0; ifSrcA = '0;
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1 first");

    // R9 independent stream
    for (int i = 1; i <= 6; i++) step(1, 0, i + 10, 0, 0, 0, "R9 indep");
    drain();

    // R5 adjacent load-use: exactly one freeze, then late forward
    bubbles = 0; sawSel = 0;
    step(1, 1, 5, 0, 0, 0, "R5 load");
    step(1, 0, 6, 5, 0, 0, "R5 use");
    drain();
    check("R5 one freeze", bubbles, 1);
    check("R5 late fwd seen", (sawSel >> 2) & 1, 1);

    // R5 load with one gap: no freeze, late forward on B
    bubbles = 0; sawSel = 0;
    step(1, 1, 6, 0, 0, 0, "R5 load gap");
    step(1, 0, 9, 0, 0, 0, "R5 gap");
    step(1, 0, 7, 0, 6, 0, "R5 use gap");
    drain();
    check("R5 gap no freeze", bubbles, 0);
    check("R5 gap late fwd", (sawSel >> 2) & 1, 1);

    // R6 ALU producer
    bubbles = 0; sawSel = 0;
    step(1, 0, 7, 0, 0, 0, "R6 alu");
    step(1, 0, 8, 7, 0, 0, "R6 use");
    drain();
    check("R6 no freeze", bubbles, 0);
    check("R6 fwd df", (sawSel >> 1) & 1, 1);

    // R4 register zero
    bubbles = 0; sawSel = 0;
    step(1, 1, 0, 0, 0, 0, "R4 load r0");
    step(1, 0, 4, 0, 0, 0, "R4 use r0");
    drain();
    check("R4 no freeze", bubbles, 0);
    check("R4 no fwd", sawSel, 0);

    // R7 priority and independent operands
    step(1, 0, 3, 0, 0, 0, "R7 w1");
    step(1, 1, 3, 0, 0, 0, "R7 w2");
    step(1, 0, 3, 0, 0, 0, "R7 w3");
    step(1, 0, 1, 0, 0, 0, "R7 w4");
    step(1, 0, 2, 0, 0, 0, "R7 w5");
    step(1, 0, 9, 3, 3, 0, "R7 use");
    step(1, 0, 9, 1, 2, 0, "R7 split");
    drain();

    // R10 fetch offered during a freeze is dropped
    step(1, 1, 8, 0, 0, 0, "R10 load");
    step(1, 0, 9, 8, 0, 0, "R10 use");
    step(1, 1, 10, 0, 0, 0, "R10 a");
    step(1, 1, 11, 9, 0, 0, "R10 b");
    step(1, 0, 12, 11, 10, 0, "R10 c");
    drain();

    // R8 flush while a freeze is due
    step(1, 1, 13, 0, 0, 0, "R8 load");
    step(1, 0, 14, 13, 0, 0, "R8 use");
    step(1, 0, 0, 0, 0, 0, "R8 n1");
    step(1, 0, 0, 0, 0, 0, "R8 n2");
    step(1, 0, 15, 0, 0, 1, "R8 flush");
    check("R8 empty", int'(stageValid), 0);
    drain();

    // mixed pseudo-random stream
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      step((seed[27:26] != 0) ? 1 : 0, seed[25] ? 1 : 0, int'(seed[23:22]),
           int'(seed[21:20]), int'(seed[19:18]),
           (seed[15:10] == 0) ? 1 : 0, "R10 mix");
    end
    drain();
    done = 1;
    finishRun();
  end
endmodule